// File: doc/BRIEF.md
# Effective Address Generator with Page-Cross Penalty

This block forms the 16-bit effective address that an 8-bit processor needs for each of its memory addressing modes. The instruction decoder pulses `start` with the addressing mode, the program counter of the first operand byte, the current X and Y index values, a per-opcode flag that allows the page-cross penalty, and the branch condition. The block then reads operand and pointer bytes one per cycle through a byte-wide read port. It finishes with a one-cycle `done` pulse. At that pulse it presents the effective address, the program counter advanced past every operand byte it consumed, and the number of extra cycles the instruction pays.

The block covers zero page, zero page indexed by X or Y, absolute, absolute indexed by X or Y, indexed-indirect, indirect-indexed, indirect jump and relative branch modes. Zero-page address arithmetic stays inside page zero. The pointer of an indirect jump never carries into its high byte. A taken branch costs one or two extra cycles, depending on whether its target leaves the page of the updated program counter. The read port is combinational: `mem_rdata` must hold the byte at `mem_addr` within the same cycle.

Top module: `eag_unit`

## Requirements
- R1: After reset, `done`, `busy` and `mem_rd` are all low.
- R2: Mode codes are 0 zero page, 1 zero page+X and 2 zero page+Y. In these modes the address is {0x00, (operand + index) mod 256}, the PC result is pc+1, and the penalty is 0.
- R3: Mode 3, absolute, reads the low byte at pc and the high byte at pc+1. The address is {high, low}, the PC result is pc+2, and the penalty is 0.
- R4: Mode 4 (absolute+X) and mode 5 (absolute+Y) give {high, low} + index with full 16-bit carry. The penalty is 1 only when low + index exceeds 0xFF and the penalty enable is set; otherwise it is 0.
- R5: Mode 6, indexed-indirect, forms the pointer p = (operand + X) mod 256. It reads the address low byte at p and the high byte at (p+1) mod 256, both in page zero. The PC result is pc+1 and the penalty is 0.
- R6: Mode 7, indirect-indexed, reads the low byte at the operand and the high byte at (operand+1) mod 256, then adds Y with full carry. The penalty follows the rule of R4, with the pointer low byte plus Y.
- R7: Mode 8, indirect jump, reads a 16-bit pointer at pc and pc+1. It reads the target low byte at the pointer and the high byte at {pointer high, (pointer low + 1) mod 256}. The PC result is pc+2 and the penalty is 0.
- R8: In mode 9, relative, the address is (pc+1) plus the operand taken as a signed byte, and the PC result is pc+1. The penalty is 0 when the branch is not taken. A taken branch costs 1 when the target's high byte equals that of pc+1, and 2 otherwise.
- R9: `done` is a one-cycle pulse. Counted in clock edges from the edge that accepts `start` to the edge that raises `done`, the latency is 2 for modes 0, 1, 2 and 9; 3 for modes 3, 4 and 5; 4 for modes 6 and 7; and 5 for mode 8. While busy, `start` and the other request inputs have no effect.
- R10: `mem_rd` is high only while an operation is in progress, and is low in the cycle after `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request pulse, accepted when idle |
| mode_i | input | 4 | Addressing mode code (0 to 9) |
| pen_en_i | input | 1 | Per-opcode page-cross penalty enable |
| taken_i | input | 1 | Branch condition for mode 9 |
| pc_i | input | 16 | Address of the first operand byte |
| x_i | input | 8 | X index value |
| y_i | input | 8 | Y index value |
| mem_rd_o | output | 1 | Read strobe for the byte port |
| mem_addr_o | output | 16 | Read address |
| mem_rdata_i | input | 8 | Byte read at mem_addr_o, same cycle |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | Result valid, one-cycle pulse |
| ea_o | output | 16 | Effective address |
| pc_o | output | 16 | Program counter past the operand bytes |
| penalty_o | output | 2 | Extra cycles charged (0, 1 or 2) |

## Verification
A wrong state transition shows up as a change in the done latency of that mode, and a stuck state as a missing `done`. Both are visible within five cycles of the request. A wrong pointer or carry path appears at the ports as a wrong address at the same `done` pulse. The bench places distinct bytes at the wrapped and the unwrapped pointer locations, so a carry into the high byte reads the wrong byte and changes `ea_o` at once. Penalty faults appear as a miscount on the same pulse, because each penalty case pairs one input pattern that crosses a page with one that does not.

// File: rtl/eag_pkg.sv
package eag_pkg;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;
    localparam int HI_W   = ADDR_W - DATA_W;

    localparam logic [ADDR_W-1:0] A_ONE = 1;
    localparam logic [DATA_W-1:0] D_ONE = 1;

    typedef enum logic [3:0] {
        AM_ZPG = 4'd0,
        AM_ZPX = 4'd1,
        AM_ZPY = 4'd2,
        AM_ABS = 4'd3,
        AM_ABX = 4'd4,
        AM_ABY = 4'd5,
        AM_IDX = 4'd6,
        AM_IDY = 4'd7,
        AM_IND = 4'd8,
        AM_REL = 4'd9
    } am_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OP0,
        ST_OP1,
        ST_PLO,
        ST_PHI,
        ST_DONE
    } st_e;

    typedef struct packed {
        st_e               st;
        am_e               mode;
        logic              pen;
        logic              taken;
        logic [ADDR_W-1:0] pc;
        logic [DATA_W-1:0] x;
        logic [DATA_W-1:0] y;
        logic [DATA_W-1:0] lo;
        logic [ADDR_W-1:0] ptr;
        logic [ADDR_W-1:0] ea;
        logic [1:0]        cost;
    } eag_state_t;

endpackage

// File: rtl/eag_index_add.sv
module eag_index_add #(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic [AW-1:0] base_i,
    input  logic [DW-1:0] idx_i,
    output logic [AW-1:0] sum_o,
    output logic          cross_o
);
    localparam int PAD_W = AW - DW;

    logic [DW:0] low_sum;

    // carry out of the low byte marks a page crossing
    assign low_sum = {1'b0, base_i[DW-1:0]} + {1'b0, idx_i};
    assign cross_o = low_sum[DW];
    assign sum_o   = base_i + {{PAD_W{1'b0}}, idx_i};
endmodule

// File: rtl/eag_branch_calc.sv
module eag_branch_calc #(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic [AW-1:0] pc_next_i,
    input  logic [DW-1:0] offset_i,
    input  logic          taken_i,
    output logic [AW-1:0] target_o,
    output logic [1:0]    cost_o
);
    localparam int PAD_W = AW - DW;

    logic same_page;

    assign target_o  = pc_next_i + {{PAD_W{offset_i[DW-1]}}, offset_i};
    assign same_page = (target_o[AW-1:DW] == pc_next_i[AW-1:DW]);

    always_comb begin
        if (!taken_i)      cost_o = 2'd0;
        else if (same_page) cost_o = 2'd1;
        else               cost_o = 2'd2;
    end
endmodule

// File: rtl/eag_unit.sv
module eag_unit
    import eag_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    input  logic [3:0]        mode_i,
    input  logic              pen_en_i,
    input  logic              taken_i,
    input  logic [ADDR_W-1:0] pc_i,
    input  logic [DATA_W-1:0] x_i,
    input  logic [DATA_W-1:0] y_i,
    output logic              mem_rd_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    input  logic [DATA_W-1:0] mem_rdata_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [ADDR_W-1:0] ea_o,
    output logic [ADDR_W-1:0] pc_o,
    output logic [1:0]        penalty_o
);
    localparam logic [HI_W-1:0] PAGE0 = '0;

    eag_state_t q, d;

    logic [ADDR_W-1:0] pc_inc;
    logic [ADDR_W-1:0] idx_sum;
    logic              idx_cross;
    logic [DATA_W-1:0] idx_val;
    logic [ADDR_W-1:0] br_target;
    logic [1:0]        br_cost;
    logic [ADDR_W-1:0] ptr_next;

    // signals exposed to the bound checker
    am_e  cur_mode;
    logic cur_pen;

    assign pc_inc   = q.pc + A_ONE;
    assign idx_val  = (q.mode == AM_ABX) ? q.x : q.y;
    // pointer increment never carries into the high byte
    assign ptr_next = {q.ptr[ADDR_W-1:DATA_W], q.ptr[DATA_W-1:0] + D_ONE};

    eag_index_add #(.AW(ADDR_W), .DW(DATA_W)) i_index_add (
        .base_i  ({mem_rdata_i, q.lo}),
        .idx_i   (idx_val),
        .sum_o   (idx_sum),
        .cross_o (idx_cross)
    );

    eag_branch_calc #(.AW(ADDR_W), .DW(DATA_W)) i_branch_calc (
        .pc_next_i (pc_inc),
        .offset_i  (mem_rdata_i),
        .taken_i   (q.taken),
        .target_o  (br_target),
        .cost_o    (br_cost)
    );

    always_comb begin
        d          = q;
        mem_rd_o   = 1'b0;
        mem_addr_o = '0;
        unique case (q.st)
            ST_IDLE: begin
                if (start_i) begin
                    d.st    = ST_OP0;
                    d.mode  = am_e'(mode_i);
                    d.pen   = pen_en_i;
                    d.taken = taken_i;
                    d.pc    = pc_i;
                    d.x     = x_i;
                    d.y     = y_i;
                    d.cost  = 2'd0;
                end
            end
            ST_OP0: begin
                mem_rd_o   = 1'b1;
                mem_addr_o = q.pc;
                d.pc       = pc_inc;
                d.lo       = mem_rdata_i;
                d.st       = ST_DONE;
                case (q.mode)
                    AM_ZPG: d.ea = {PAGE0, mem_rdata_i};
                    AM_ZPX: d.ea = {PAGE0, mem_rdata_i + q.x};
                    AM_ZPY: d.ea = {PAGE0, mem_rdata_i + q.y};
                    AM_IDX: begin
                        d.ptr = {PAGE0, mem_rdata_i + q.x};
                        d.st  = ST_PLO;
                    end
                    AM_IDY: begin
                        d.ptr = {PAGE0, mem_rdata_i};
                        d.st  = ST_PLO;
                    end
                    AM_REL: begin
                        d.ea   = br_target;
                        d.cost = br_cost;
                    end
                    default: d.st = ST_OP1;
                endcase
            end
            ST_OP1: begin
                mem_rd_o   = 1'b1;
                mem_addr_o = q.pc;
                d.pc       = pc_inc;
                d.st       = ST_DONE;
                case (q.mode)
                    AM_ABX, AM_ABY: begin
                        d.ea   = idx_sum;
                        d.cost = {1'b0, idx_cross & q.pen};
                    end
                    AM_IND: begin
                        d.ptr = {mem_rdata_i, q.lo};
                        d.st  = ST_PLO;
                    end
                    default: d.ea = {mem_rdata_i, q.lo};
                endcase
            end
            ST_PLO: begin
                mem_rd_o   = 1'b1;
                mem_addr_o = q.ptr;
                d.lo       = mem_rdata_i;
                d.st       = ST_PHI;
            end
            ST_PHI: begin
                mem_rd_o   = 1'b1;
                mem_addr_o = ptr_next;
                d.st       = ST_DONE;
                if (q.mode == AM_IDY) begin
                    d.ea   = idx_sum;
                    d.cost = {1'b0, idx_cross & q.pen};
                end else begin
                    d.ea = {mem_rdata_i, q.lo};
                end
            end
            ST_DONE: d.st = ST_IDLE;
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q       <= '0;
            q.st    <= ST_IDLE;
            q.mode  <= AM_ZPG;
        end else begin
            q <= d;
        end
    end

    assign busy_o    = (q.st != ST_IDLE);
    assign done_o    = (q.st == ST_DONE);
    assign ea_o      = q.ea;
    assign pc_o      = q.pc;
    assign penalty_o = q.cost;
    assign cur_mode  = q.mode;
    assign cur_pen   = q.pen;
endmodule

// File: rtl/eag_unit_chk.sv
module eag_unit_chk
    import eag_pkg::*;
(
    input logic              clk_i,
    input logic              rst_ni,
    input logic              start_i,
    input logic              busy_i,
    input logic              done_i,
    input logic              mem_rd_i,
    input logic [ADDR_W-1:0] ea_i,
    input logic [1:0]        penalty_i,
    input am_e               mode_i,
    input logic              pen_i
);
    // R9
    done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_i |=> !done_i);

    // R9
    busy_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(busy_i) |-> $past(start_i));

    // R10
    rd_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mem_rd_i |-> busy_i);

    // R2
    zp_page_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_i && (mode_i == AM_ZPG || mode_i == AM_ZPX || mode_i == AM_ZPY))
        |-> (ea_i[ADDR_W-1:DATA_W] == '0));

    // R4
    pen_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_i && !pen_i && mode_i != AM_REL) |-> (penalty_i == 2'd0));

    // R5
    idx_free_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_i && mode_i == AM_IDX) |-> (penalty_i == 2'd0));

    // R8
    pen_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_i |-> (penalty_i != 2'd3));
endmodule

bind eag_unit eag_unit_chk i_eag_unit_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .busy_i    (busy_o),
    .done_i    (done_o),
    .mem_rd_i  (mem_rd_o),
    .ea_i      (ea_o),
    .penalty_i (penalty_o),
    .mode_i    (cur_mode),
    .pen_i     (cur_pen)
);

// File: tb/test_eag_unit.sv
`timescale 1ns/1ps
module test_eag_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  mode = 4'd0;
    logic        pen_en = 1'b0;
    logic        taken = 1'b0;
    logic [15:0] pc = 16'h0;
    logic [7:0]  x = 8'h0;
    logic [7:0]  y = 8'h0;
    logic        mem_rd;
    logic [15:0] mem_addr;
    logic [7:0]  mem_rdata;
    logic        busy, done;
    logic [15:0] ea, pc_out;
    logic [1:0]  penalty;

    int n_chk = 0;
    int n_fail = 0;

    logic [15:0] ov_addr [16];
    logic [7:0]  ov_data [16];
    logic        ov_vld  [16];
    int          ov_n = 0;

    always #2.5 clk = ~clk;

    eag_unit i_eag_unit (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode),
        .pen_en_i(pen_en), .taken_i(taken), .pc_i(pc), .x_i(x), .y_i(y),
        .mem_rd_o(mem_rd), .mem_addr_o(mem_addr), .mem_rdata_i(mem_rdata),
        .busy_o(busy), .done_o(done), .ea_o(ea), .pc_o(pc_out),
        .penalty_o(penalty)
    );

    // sparse byte memory: default pattern plus a few written locations
    always_comb begin
        mem_rdata = mem_addr[7:0] ^ mem_addr[15:8] ^ 8'hA5;
        for (int i = 0; i < 16; i++)
            if (ov_vld[i] && ov_addr[i] == mem_addr) mem_rdata = ov_data[i];
    end

    task automatic mem_clear();
        for (int i = 0; i < 16; i++) ov_vld[i] = 1'b0;
        ov_n = 0;
    endtask

    task automatic poke(input logic [15:0] a, input logic [7:0] v);
        ov_addr[ov_n] = a; ov_data[ov_n] = v; ov_vld[ov_n] = 1'b1;
        ov_n++;
    endtask

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic do_op(input string req, input logic [3:0] m, input logic pe,
                         input logic tk, input logic [15:0] p,
                         input logic [7:0] xv, input logic [7:0] yv,
                         input logic [15:0] exp_ea, input logic [15:0] exp_pc,
                         input logic [1:0] exp_pen, input int exp_lat,
                         input int hold);
        int lat;
        @(negedge clk);
        start = 1'b1; mode = m; pen_en = pe; taken = tk; pc = p; x = xv; y = yv;
        @(negedge clk);
        lat = 1;
        if (hold == 0) start = 1'b0;
        else begin
            // R9: change the request while busy; it must be ignored
            mode = 4'd0; pc = 16'hFFFF; x = 8'h77; y = 8'h77;
        end
        while (!done && lat < 40) begin
            @(negedge clk);
            lat++;
        end
        start = 1'b0;
        check(req, "done seen", {31'd0, done}, 32'd1);
        check(req, "ea", {16'd0, ea}, {16'd0, exp_ea});
        check(req, "pc", {16'd0, pc_out}, {16'd0, exp_pc});
        check(req, "penalty", {30'd0, penalty}, {30'd0, exp_pen});
        check("R9", "latency", lat, exp_lat);
        @(negedge clk);
        check("R9", "done pulse", {31'd0, done}, 32'd0);
        check("R10", "mem_rd idle", {31'd0, mem_rd}, 32'd0);
        check("R10", "busy idle", {31'd0, busy}, 32'd0);
    endtask

    task automatic t_reset();
        check("R1", "done", {31'd0, done}, 32'd0);
        check("R1", "busy", {31'd0, busy}, 32'd0);
        check("R1", "mem_rd", {31'd0, mem_rd}, 32'd0);
    endtask

    task automatic t_zero_page();
        mem_clear();
        poke(16'h0200, 8'h34);
        do_op("R2", 4'd0, 1'b1, 1'b0, 16'h0200, 8'h10, 8'h20, 16'h0034, 16'h0201, 2'd0, 2, 0);
        poke(16'h0210, 8'hF0);
        do_op("R2", 4'd1, 1'b1, 1'b0, 16'h0210, 8'h20, 8'h00, 16'h0010, 16'h0211, 2'd0, 2, 0);
        poke(16'h0220, 8'h80);
        do_op("R2", 4'd2, 1'b1, 1'b0, 16'h0220, 8'h00, 8'h85, 16'h0005, 16'h0221, 2'd0, 2, 0);
    endtask

    task automatic t_absolute();
        mem_clear();
        poke(16'h0300, 8'h78); poke(16'h0301, 8'h56);
        do_op("R3", 4'd3, 1'b1, 1'b0, 16'h0300, 8'hFF, 8'hFF, 16'h5678, 16'h0302, 2'd0, 3, 0);
    endtask

    task automatic t_abs_indexed();
        mem_clear();
        poke(16'h0310, 8'hF0); poke(16'h0311, 8'h12);
        do_op("R4", 4'd4, 1'b1, 1'b0, 16'h0310, 8'h20, 8'h00, 16'h1310, 16'h0312, 2'd1, 3, 0);
        do_op("R4", 4'd4, 1'b0, 1'b0, 16'h0310, 8'h20, 8'h00, 16'h1310, 16'h0312, 2'd0, 3, 0);
        do_op("R4", 4'd5, 1'b1, 1'b0, 16'h0310, 8'h40, 8'h0F, 16'h12FF, 16'h0312, 2'd0, 3, 0);
    endtask

    task automatic t_indirect_zp();
        mem_clear();
        poke(16'h0400, 8'hFE); poke(16'h00FF, 8'h21); poke(16'h0000, 8'h43);
        poke(16'h0100, 8'h99);
        do_op("R5", 4'd6, 1'b1, 1'b0, 16'h0400, 8'h01, 8'h00, 16'h4321, 16'h0401, 2'd0, 4, 0);
        poke(16'h0410, 8'hFF);
        do_op("R6", 4'd7, 1'b1, 1'b0, 16'h0410, 8'h00, 8'hE0, 16'h4401, 16'h0411, 2'd1, 4, 0);
        do_op("R6", 4'd7, 1'b0, 1'b0, 16'h0410, 8'h00, 8'hE0, 16'h4401, 16'h0411, 2'd0, 4, 0);
        do_op("R6", 4'd7, 1'b1, 1'b0, 16'h0410, 8'h00, 8'h10, 16'h4331, 16'h0411, 2'd0, 4, 0);
    endtask

    task automatic t_jump_indirect();
        mem_clear();
        poke(16'h0500, 8'hFF); poke(16'h0501, 8'h30);
        poke(16'h30FF, 8'h9A); poke(16'h3000, 8'hBC); poke(16'h3100, 8'hDE);
        do_op("R7", 4'd8, 1'b1, 1'b0, 16'h0500, 8'h00, 8'h00, 16'hBC9A, 16'h0502, 2'd0, 5, 0);
    endtask

    task automatic t_branch();
        mem_clear();
        poke(16'h0610, 8'h10);
        do_op("R8", 4'd9, 1'b0, 1'b1, 16'h0610, 8'h00, 8'h00, 16'h0621, 16'h0611, 2'd1, 2, 0);
        poke(16'h0700, 8'h80);
        do_op("R8", 4'd9, 1'b0, 1'b1, 16'h0700, 8'h00, 8'h00, 16'h0681, 16'h0701, 2'd2, 2, 0);
        do_op("R8", 4'd9, 1'b0, 1'b0, 16'h0700, 8'h00, 8'h00, 16'h0681, 16'h0701, 2'd0, 2, 0);
    endtask

    task automatic t_start_while_busy();
        mem_clear();
        poke(16'h0500, 8'hFF); poke(16'h0501, 8'h30);
        poke(16'h30FF, 8'h9A); poke(16'h3000, 8'hBC);
        do_op("R9", 4'd8, 1'b1, 1'b0, 16'h0500, 8'h00, 8'h00, 16'hBC9A, 16'h0502, 2'd0, 5, 1);
    endtask

    initial begin
        #20000;
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        mem_clear();
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_zero_page();
        t_absolute();
        t_abs_indexed();
        t_indirect_zp();
        t_jump_indirect();
        t_branch();
        t_start_while_busy();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule